// File: doc/BRIEF.md
# Two-Row Sixteen-Segment Display Frame Latch

This block sits between a processor's byte-wide register port and a two-row bank of sixteen-segment character digits. Software first picks a digit position, then deposits the low and high segment bytes of that digit for either row. Every byte written is merged by bitwise OR into a 16-bit word held for that digit. Bits already set stay set until the next frame.

A frame strobe, nominally at 60 Hz, turns the accumulated words into a picture. On the strobe the block copies sixteen digits of each row into a registered 32-entry output array. On the way out each word's bits are reordered into the order the segment drivers expect. The whole word store is then wiped, so software rebuilds each frame from scratch. Between strobes the output array does not change.

The store holds 40 words. Row one uses words 0 to 19 and row two uses words 20 to 39. Only the first sixteen words of each row reach the output.

Top module: `seg16_frame_latch`

## Requirements
- R1: A write to offset 0x3B loads bits 4:0 of the data byte into the position register; bits 7:5 are discarded.
- R2: A write to offset 0x3C ORs the data byte into bits 7:0 of word[pos]. A write to offset 0x3D ORs it into bits 15:8 of the same word. Repeated writes accumulate.
- R3: Writes to offsets 0x3E (bits 7:0) and 0x3F (bits 15:8) OR into word[pos+20]. When pos+20 exceeds 39, the write changes nothing.
- R4: Row-one writes always target word[pos], even for pos 16 to 31. So pos 20 to 31 land in row-two words, and pos 16 to 19 land in words that are never shown.
- R5: On a frame strobe, output entry i (0..15) takes word[i] and output entry 16+i takes word[20+i], after reordering. The new values are visible from the clock edge that samples the strobe.
- R6: Reordered output bits 15 down to 0 come from stored bits 7, 15, 12, 10, 8, 14, 13, 9, 11, 6, 5, 4, 3, 2, 1, 0 respectively.
- R7: In the cycle after a frame strobe, all 40 stored words are zero.
- R8: The output array holds its value on every cycle without a frame strobe.
- R9: Reset clears the word store, the output array and the position register.
- R10: Any write presented in the same cycle as a frame strobe is discarded, including a position write; the clear takes priority.
- R11: Writes with the write enable low, and writes to any other offset, change neither the store nor the position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe, one byte per cycle |
| wr_addr | input | 7 | Byte offset within the register window |
| wr_data | input | 8 | Write data byte |
| frame_tick | input | 1 | One-cycle frame strobe: publish, then clear |
| seg_out | output | 32x16 | Registered, reordered segment words, entry 0 first |

## Verification
The assertions assume that the write strobe, offset and data are stable, known values at each clock edge. They also assume the frame strobe is a plain single-cycle pulse, which may coincide with a write. The stimulus follows this. It drives every input on the falling edge, fires strobes at random or directed points, and deliberately overlaps strobes with writes. Offsets are drawn mostly from the five live registers, with some drawn from the rest of the window to exercise the ignore path. Positions cover the full 5-bit range, so row-two writes past the store's end and row-one writes into row-two words both occur.

// File: rtl/seg16_pkg.sv
package seg16_pkg;

    localparam int ADDR_W    = 7;
    localparam int DATA_W    = 8;
    localparam int WORD_W    = 2 * DATA_W;
    localparam int POS_W     = 5;
    localparam int NUM_WORDS = 40;
    localparam int ROW2_BASE = 20;
    localparam int DIGITS    = 16;
    localparam int NUM_OUT   = 2 * DIGITS;
    localparam int IDX_W     = $clog2(NUM_WORDS);

    // register offsets; software decodes these exact values
    localparam logic [ADDR_W-1:0] OFS_POS    = 7'h3B;
    localparam logic [ADDR_W-1:0] OFS_R1_LO  = 7'h3C;
    localparam logic [ADDR_W-1:0] OFS_R1_HI  = 7'h3D;
    localparam logic [ADDR_W-1:0] OFS_R2_LO  = 7'h3E;
    localparam logic [ADDR_W-1:0] OFS_R2_HI  = 7'h3F;

    typedef enum logic [2:0] {
        OP_IDLE,
        OP_POS,
        OP_R1_LO,
        OP_R1_HI,
        OP_R2_LO,
        OP_R2_HI
    } op_e;

    typedef struct packed {
        op_e                op;
        logic [DATA_W-1:0]  data;
    } cmd_t;

    typedef logic [NUM_WORDS-1:0][WORD_W-1:0] store_arr_t;

    typedef struct packed {
        logic [POS_W-1:0] pos;
        store_arr_t       words;
    } store_t;

    // source bit for each output bit, entry 0 feeds output MSB
    localparam int SEG_SRC [WORD_W] = '{7, 15, 12, 10, 8, 14, 13, 9,
                                        11, 6, 5, 4, 3, 2, 1, 0};

    function automatic logic [WORD_W-1:0] seg_reorder(input logic [WORD_W-1:0] w);
        logic [WORD_W-1:0] r;
        for (int k = 0; k < WORD_W; k++) begin
            r[WORD_W-1-k] = w[SEG_SRC[k]];
        end
        return r;
    endfunction

endpackage

// File: rtl/seg16_reg_decode.sv
module seg16_reg_decode
    import seg16_pkg::*;
(
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output cmd_t              cmd
);

    always_comb begin
        cmd.data = wr_data;
        cmd.op   = OP_IDLE;
        if (wr_en) begin
            case (wr_addr)
                OFS_POS:   cmd.op = OP_POS;
                OFS_R1_LO: cmd.op = OP_R1_LO;
                OFS_R1_HI: cmd.op = OP_R1_HI;
                OFS_R2_LO: cmd.op = OP_R2_LO;
                OFS_R2_HI: cmd.op = OP_R2_HI;
                default:   cmd.op = OP_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/seg16_word_store.sv
module seg16_word_store
    import seg16_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  cmd_t             cmd,
    input  logic             frame_tick,
    output logic [POS_W-1:0] pos_q,
    output store_arr_t       words_q
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_WORDS - 1);
    localparam logic [IDX_W-1:0] R2_OFS   = IDX_W'(ROW2_BASE);

    store_t            st_d, st_q;
    logic [IDX_W-1:0]  row2_idx;

    always_comb begin
        st_d     = st_q;
        row2_idx = IDX_W'(st_q.pos) + R2_OFS;
        if (frame_tick) begin
            // clear wins over any write in the same cycle
            st_d.words = '0;
        end else begin
            case (cmd.op)
                OP_POS:   st_d.pos = cmd.data[POS_W-1:0];
                OP_R1_LO: st_d.words[st_q.pos][DATA_W-1:0] =
                              st_q.words[st_q.pos][DATA_W-1:0] | cmd.data;
                OP_R1_HI: st_d.words[st_q.pos][WORD_W-1:DATA_W] =
                              st_q.words[st_q.pos][WORD_W-1:DATA_W] | cmd.data;
                OP_R2_LO: if (row2_idx <= LAST_IDX) begin
                              st_d.words[row2_idx][DATA_W-1:0] =
                                  st_q.words[row2_idx][DATA_W-1:0] | cmd.data;
                          end
                OP_R2_HI: if (row2_idx <= LAST_IDX) begin
                              st_d.words[row2_idx][WORD_W-1:DATA_W] =
                                  st_q.words[row2_idx][WORD_W-1:DATA_W] | cmd.data;
                          end
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pos_q   = st_q.pos;
    assign words_q = st_q.words;

endmodule

// File: rtl/seg16_publish.sv
module seg16_publish
    import seg16_pkg::*;
(
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            frame_tick,
    input  store_arr_t                      words_q,
    output logic [NUM_OUT-1:0][WORD_W-1:0]  out_q
);

    logic [NUM_OUT-1:0][WORD_W-1:0] out_d;

    for (genvar i = 0; i < NUM_OUT; i++) begin : g_lane
        localparam int SRC = (i < DIGITS) ? i : ROW2_BASE + i - DIGITS;
        assign out_d[i] = frame_tick ? seg_reorder(words_q[SRC]) : out_q[i];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

endmodule

// File: rtl/seg16_frame_latch.sv
module seg16_frame_latch
    import seg16_pkg::*;
(
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_en,
    input  logic [ADDR_W-1:0]               wr_addr,
    input  logic [DATA_W-1:0]               wr_data,
    input  logic                            frame_tick,
    output logic [NUM_OUT-1:0][WORD_W-1:0]  seg_out
);

    cmd_t             cmd;
    logic [POS_W-1:0] pos_q;
    store_arr_t       words_q;

    seg16_reg_decode u_decode (
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .cmd     (cmd)
    );

    seg16_word_store u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd        (cmd),
        .frame_tick (frame_tick),
        .pos_q      (pos_q),
        .words_q    (words_q)
    );

    seg16_publish u_publish (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_tick (frame_tick),
        .words_q    (words_q),
        .out_q      (seg_out)
    );

endmodule

// File: rtl/seg16_frame_latch_checker.sv
module seg16_frame_latch_checker
    import seg16_pkg::*;
(
    input logic                            clk,
    input logic                            rst_n,
    input logic                            wr_en,
    input logic [ADDR_W-1:0]               wr_addr,
    input logic [DATA_W-1:0]               wr_data,
    input logic                            frame_tick,
    input logic [POS_W-1:0]                pos_q,
    input store_arr_t                      words_q,
    input logic [NUM_OUT-1:0][WORD_W-1:0]  seg_out
);

    // R1: position load keeps the low five bits
    a_r1_pos_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == OFS_POS && !frame_tick) |=> pos_q == $past(wr_data[POS_W-1:0]));

    // R2: a low-byte write leaves all its bits set in the addressed word
    a_r2_or_low: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == OFS_R1_LO && !frame_tick) |=>
        ((words_q[$past(pos_q)][DATA_W-1:0] & $past(wr_data)) == $past(wr_data)));

    // R7: the store is empty after a strobe
    a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
        frame_tick |=> words_q == '0);

    // R8: no strobe, no change at the output
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_tick |=> $stable(seg_out));

    // R10: a position write during a strobe is dropped
    a_r10_collision: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_tick && wr_en) |=> pos_q == $past(pos_q));

endmodule

bind seg16_frame_latch seg16_frame_latch_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .frame_tick (frame_tick),
    .pos_q      (pos_q),
    .words_q    (words_q),
    .seg_out    (seg_out)
);

// File: tb/seg16_frame_latch_bench.sv
module seg16_frame_latch_bench;
    import seg16_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic                            clk = 1'b0;
    logic                            rst_n = 1'b0;
    logic                            wr_en = 1'b0;
    logic [ADDR_W-1:0]               wr_addr = '0;
    logic [DATA_W-1:0]               wr_data = '0;
    logic                            frame_tick = 1'b0;
    logic [NUM_OUT-1:0][WORD_W-1:0]  seg_out;

    int n_checks = 0;
    int n_fails  = 0;

    logic [WORD_W-1:0] m_words [NUM_WORDS];
    logic [WORD_W-1:0] m_out   [NUM_OUT];
    logic [POS_W-1:0]  m_pos;

    always #(CLK_PERIOD/2) clk = ~clk;

    seg16_frame_latch u_seg16_frame_latch (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .frame_tick(frame_tick), .seg_out(seg_out)
    );

    // R6 output order, written from the requirement
    function automatic logic [WORD_W-1:0] exp_reorder(input logic [WORD_W-1:0] w);
        int src [16] = '{7, 15, 12, 10, 8, 14, 13, 9, 11, 6, 5, 4, 3, 2, 1, 0};
        logic [WORD_W-1:0] r;
        for (int k = 0; k < 16; k++) r[15-k] = w[src[k]];
        return r;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < NUM_WORDS; i++) m_words[i] = '0;
        for (int i = 0; i < NUM_OUT; i++)   m_out[i] = '0;
        m_pos = '0;
    endtask

    task automatic model_step(input logic we, input logic [6:0] a,
                              input logic [7:0] d, input logic tk);
        int idx;
        if (tk) begin
            for (int i = 0; i < 16; i++) begin
                m_out[i]    = exp_reorder(m_words[i]);
                m_out[16+i] = exp_reorder(m_words[20+i]);
            end
            for (int i = 0; i < NUM_WORDS; i++) m_words[i] = '0;
        end else if (we) begin
            idx = int'(m_pos) + 20;
            case (a)
                7'h3B: m_pos = d[4:0];
                7'h3C: m_words[m_pos][7:0]  |= d;
                7'h3D: m_words[m_pos][15:8] |= d;
                7'h3E: if (idx < 40) m_words[idx][7:0]  |= d;
                7'h3F: if (idx < 40) m_words[idx][15:8] |= d;
                default: ;
            endcase
        end
    endtask

    task automatic cyc(input logic we, input logic [6:0] a,
                       input logic [7:0] d, input logic tk);
        @(negedge clk);
        wr_en = we; wr_addr = a; wr_data = d; frame_tick = tk;
        @(posedge clk);
        #1;
        model_step(we, a, d, tk);
        wr_en = 1'b0; frame_tick = 1'b0;
    endtask

    task automatic wr(input logic [6:0] a, input logic [7:0] d);
        cyc(1'b1, a, d, 1'b0);
    endtask

    task automatic tick();
        cyc(1'b0, 7'h00, 8'h00, 1'b1);
    endtask

    task automatic check_out(input string req);
        bit bad = 0;
        @(negedge clk);
        n_checks++;
        for (int i = 0; i < NUM_OUT; i++) begin
            if (seg_out[i] !== m_out[i]) begin
                $display("FAIL %s entry %0d actual %h expected %h", req, i, seg_out[i], m_out[i]);
                bad = 1;
            end
        end
        if (bad) n_fails++;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fails++;
        $display("FAIL watchdog actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        check_out("R9");

        // R6: walk a single stored bit through every position
        for (int b = 0; b < 16; b++) begin
            wr(7'h3B, 8'h00);
            if (b < 8) wr(7'h3C, 8'(1 << b));
            else       wr(7'h3D, 8'(1 << (b - 8)));
            tick();
            check_out("R6");
        end

        // R1 upper bits dropped, R2 accumulation
        wr(7'h3B, 8'hE3);
        wr(7'h3C, 8'h0F); wr(7'h3C, 8'hF0); wr(7'h3D, 8'h01); wr(7'h3D, 8'h80);
        tick(); check_out("R1");
        wr(7'h3B, 8'h07); wr(7'h3C, 8'h11); wr(7'h3C, 8'h22);
        tick(); check_out("R2");

        // R3 row two, in range and past the store end
        wr(7'h3B, 8'h05); wr(7'h3E, 8'hA5); wr(7'h3F, 8'h5A);
        wr(7'h3B, 8'h13); wr(7'h3F, 8'hFF);
        wr(7'h3B, 8'h19); wr(7'h3E, 8'hFF); wr(7'h3F, 8'hFF);
        tick(); check_out("R3");

        // R4 row-one aliasing into row two, hidden words 16..19
        wr(7'h3B, 8'h16); wr(7'h3C, 8'hAA);
        wr(7'h3B, 8'h11); wr(7'h3C, 8'h55); wr(7'h3D, 8'h55);
        tick(); check_out("R4");

        // R7 store empty after publish
        tick(); check_out("R7");

        // R10 writes during a strobe vanish, position too
        wr(7'h3B, 8'h02);
        cyc(1'b1, 7'h3C, 8'hFF, 1'b1);
        cyc(1'b1, 7'h3B, 8'h09, 1'b1);
        wr(7'h3D, 8'h44);
        tick(); check_out("R10");

        // R11 disabled writes and foreign offsets
        cyc(1'b0, 7'h3C, 8'hFF, 1'b0);
        wr(7'h3A, 8'hFF); wr(7'h40, 8'h1F); wr(7'h0C, 8'hFF); wr(7'h4F, 8'hFF);
        wr(7'h3D, 8'h01);
        tick(); check_out("R11");

        // R8 output holds while the store fills
        wr(7'h3B, 8'h00); wr(7'h3C, 8'h77);
        check_out("R8");
        wr(7'h3E, 8'h33);
        check_out("R8");
        tick(); check_out("R5");

        // random mix, R5 across many frames
        for (int n = 0; n < 3000; n++) begin
            logic [6:0] a;
            logic [7:0] d;
            logic       we, tk;
            a  = ($urandom % 8 == 0) ? 7'($urandom % 80) : 7'(7'h3B + $urandom % 5);
            d  = 8'($urandom);
            we = ($urandom % 8) != 0;
            tk = ($urandom % 16) == 0;
            cyc(we, a, d, tk);
            if (tk) check_out("R5");
        end
        tick(); check_out("R5");

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule